// File: doc/BRIEF.md
# Offset Register Loader for a 512-Word FIFO

This unit produces the two threshold values that a 512-word FIFO compares against its fill level: an almost-empty offset (X) and an almost-full offset (Y), each 9 bits wide. The loading method is chosen while reset is held. Two select pins and a serial-mode pin are sampled on every clock edge during reset. The value present at the last reset edge stays in force until the next reset.

Three methods are available. The first is a fixed preset of 8, 16 or 64, written into both registers. The second is a parallel load taken from the write-port data bus over two writes. The third is a bit-serial load. After reset, the two select pins change roles: they become a serial enable and a serial data line, both clocked by the write clock. The serial stream fills Y first and then X, most significant bit first. A done output tells the surrounding FIFO when the offsets are final.

During a serial load, X and Y show the partially shifted value. Once done is high, both offsets stay frozen until the next reset.

Top module: `ofs_prog`

## Requirements
- R1: While `rst_n` is low, every clock edge clears X, Y and done and samples `sel_hi`, `sel_lo` and `ser_mode`. The value sampled at the last reset edge selects the method until the next reset. Later changes to `ser_mode` have no effect.
- R2: A nonzero `{sel_hi, sel_lo}` selects a preset regardless of `ser_mode`. The code 01 loads 8, 10 loads 16 and 11 loads 64, into both X and Y.
- R3: In preset mode, X, Y and done take their final values on the first clock edge after `rst_n` goes high.
- R4: `{sel_hi, sel_lo}` = 00 with `ser_mode` low selects parallel load. The first edge with `wr_en` high loads X from `wr_data[8:0]`. The second such edge loads Y from `wr_data[8:0]` and raises done. Edges with `wr_en` low change nothing.
- R5: `wr_en` and `wr_data` have no effect in preset or serial mode, nor after a parallel load has finished.
- R6: `{sel_hi, sel_lo}` = 00 with `ser_mode` high selects serial load. Each edge with `sel_hi` low shifts `sel_lo` into the 18-bit chain `{Y, X}` at its LSB end. Edges with `sel_hi` high leave X and Y unchanged, whatever `sel_lo` carries.
- R7: After 18 serial bits, the first bit sits in Y[8] and the last bit sits in X[0].
- R8: In serial mode, done rises on the edge that captures the 18th bit and not earlier.
- R9: Serial bits offered after the 18th leave X and Y unchanged.
- R10: Once done is high, it stays high and X and Y hold steady until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-port clock |
| rst_n | input | 1 | Synchronous active-low reset; method sampled while low |
| sel_hi | input | 1 | Preset select high bit during reset; active-low serial enable afterwards |
| sel_lo | input | 1 | Preset select low bit during reset; serial data afterwards |
| ser_mode | input | 1 | Chooses serial over parallel when both selects are low during reset |
| wr_en | input | 1 | Write enable of the write port, used for parallel load |
| wr_data | input | 36 | Write-port data bus; bits [8:0] feed the offsets |
| ofs_x | output | 9 | Almost-empty offset |
| ofs_y | output | 9 | Almost-full offset |
| done | output | 1 | High once the offsets are final |

## Verification
The bench checks several corner cases, each chosen to expose a specific design error:
- Bit order: a stream carrying a single one in the first position, and another carrying a single one in the last. A design with a reversed chain would put the one at X[0] instead of Y[8].
- Latching: select pins that change between reset edges, and pins that toggle after release. A design that latched the method too early, or kept watching the pins after reset, would load the wrong preset.
- Serial gaps: gaps with the serial enable high while the data line carries noise. A design that shifted in those gaps would corrupt the chain. Extra bits sent after the 18th would expose a counter that does not stop.
- Parallel load: a third write after the two loads. An off-by-one counter would raise done early or overwrite Y.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    typedef enum logic [1:0] {
        METH_PAR = 2'd0,
        METH_SER = 2'd1,
        METH_PRE = 2'd2
    } meth_e;

    // preset code -> offset value; the offset width must hold 64
    function automatic int unsigned preset_val(input logic [1:0] code);
        case (code)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
    import ofs_prog_pkg::*;
(
    input  logic       sel_hi,
    input  logic       sel_lo,
    input  logic       ser_mode,
    output meth_e      meth,
    output logic [1:0] code
);
    always_comb begin
        code = {sel_hi, sel_lo};
        if (code != 2'b00) begin
            meth = METH_PRE;
        end else if (ser_mode) begin
            meth = METH_SER;
        end else begin
            meth = METH_PAR;
        end
    end
endmodule

// File: rtl/ofs_step_counter.sv
module ofs_step_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ofs_prog.sv
module ofs_prog
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W     = 36,
    parameter int FIFO_DEPTH = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel_hi,
    input  logic                            sel_lo,
    input  logic                            ser_mode,
    input  logic                            wr_en,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [$clog2(FIFO_DEPTH)-1:0]   ofs_x,
    output logic [$clog2(FIFO_DEPTH)-1:0]   ofs_y,
    output logic                            done
);
    localparam int OFS_W    = $clog2(FIFO_DEPTH);
    localparam int SER_BITS = 2 * OFS_W;
    localparam int CNT_W    = $clog2(SER_BITS + 1);

    typedef struct packed {
        meth_e            meth;
        logic [1:0]       pcode;
        logic [OFS_W-1:0] x;
        logic [OFS_W-1:0] y;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    meth_e               dec_meth;
    logic [1:0]          dec_code;
    logic                step;
    logic [CNT_W-1:0]    cnt_q;
    logic [SER_BITS-1:0] chain;
    meth_e               meth_q;
    logic                wr_data_unused;

    assign wr_data_unused = ^wr_data[DATA_W-1:OFS_W];

    ofs_mode_decode u_dec (
        .sel_hi   (sel_hi),
        .sel_lo   (sel_lo),
        .ser_mode (ser_mode),
        .meth     (dec_meth),
        .code     (dec_code)
    );

    ofs_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .clr (!rst_n),
        .inc (step),
        .cnt (cnt_q)
    );

    always_comb begin
        st_d  = st_q;
        step  = 1'b0;
        chain = {st_q.y, st_q.x};
        if (!rst_n) begin
            st_d.meth  = dec_meth;
            st_d.pcode = dec_code;
            st_d.x     = '0;
            st_d.y     = '0;
            st_d.done  = 1'b0;
        end else if (!st_q.done) begin
            case (st_q.meth)
                METH_PRE: begin
                    st_d.x    = OFS_W'(preset_val(st_q.pcode));
                    st_d.y    = OFS_W'(preset_val(st_q.pcode));
                    st_d.done = 1'b1;
                end
                METH_PAR: begin
                    if (wr_en) begin
                        step = 1'b1;
                        if (cnt_q == '0) begin
                            st_d.x = wr_data[OFS_W-1:0];
                        end else begin
                            st_d.y    = wr_data[OFS_W-1:0];
                            st_d.done = 1'b1;
                        end
                    end
                end
                METH_SER: begin
                    if (!sel_hi) begin
                        step   = 1'b1;
                        chain  = {chain[SER_BITS-2:0], sel_lo};
                        st_d.y = chain[SER_BITS-1:OFS_W];
                        st_d.x = chain[OFS_W-1:0];
                        if (cnt_q == CNT_W'(SER_BITS - 1)) begin
                            st_d.done = 1'b1;
                        end
                    end
                end
                default: st_d.done = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign meth_q = st_q.meth;
    assign ofs_x  = st_q.x;
    assign ofs_y  = st_q.y;
    assign done   = st_q.done;
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk
    import ofs_prog_pkg::*;
#(
    parameter int FIFO_DEPTH = 512
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 sel_hi,
    input meth_e                                meth_q,
    input logic [$clog2(2*$clog2(FIFO_DEPTH)+1)-1:0] cnt_q,
    input logic [$clog2(FIFO_DEPTH)-1:0]        ofs_x,
    input logic [$clog2(FIFO_DEPTH)-1:0]        ofs_y,
    input logic                                 done
);
    localparam int OFS_W    = $clog2(FIFO_DEPTH);
    localparam int SER_BITS = 2 * OFS_W;
    localparam int CNT_W    = $clog2(SER_BITS + 1);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(ofs_x) && $stable(ofs_y)));

    // R6
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meth_q == METH_SER && !done && sel_hi) |=> ($stable(ofs_x) && $stable(ofs_y)));

    // R2
    preset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meth_q == METH_PRE && done) |->
        (ofs_x == ofs_y && (ofs_x == OFS_W'(8) || ofs_x == OFS_W'(16) || ofs_x == OFS_W'(64))));

    // R8
    ser_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meth_q == METH_SER) |-> (done == (cnt_q == CNT_W'(SER_BITS))));

    // R4
    par_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meth_q == METH_PAR) |-> (done == (cnt_q == CNT_W'(2))));
endmodule

bind ofs_prog ofs_prog_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_hi (sel_hi),
    .meth_q (meth_q),
    .cnt_q  (cnt_q),
    .ofs_x  (ofs_x),
    .ofs_y  (ofs_y),
    .done   (done)
);

// File: tb/ofs_prog_tb.sv
module ofs_prog_tb;
    localparam int OFS_W    = 9;
    localparam int SER_BITS = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_hi = 1'b0, sel_lo = 1'b0, ser_mode = 1'b0, wr_en = 1'b0;
    logic [35:0]       wr_data = '0;
    logic [OFS_W-1:0]  ofs_x, ofs_y;
    logic              done;
    int                n_chk = 0;
    int                n_fail = 0;

    always #5 clk = ~clk;

    ofs_prog u_dut (
        .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .ser_mode(ser_mode), .wr_en(wr_en), .wr_data(wr_data),
        .ofs_x(ofs_x), .ofs_y(ofs_y), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [OFS_W-1:0] preset_exp(input logic [1:0] c);
        case (c)
            2'b01:   return 9'd8;
            2'b10:   return 9'd16;
            default: return 9'd64;
        endcase
    endfunction

    // Noise on the write bus, used where it must be ignored (R5)
    task automatic noise_bus();
        wr_en   = 1'($urandom);
        wr_data = {4'($urandom), 32'($urandom)};
    endtask

    // Hold reset with given pins, check cleared outputs, release (R1)
    task automatic do_reset(input logic hi, input logic lo, input logic sm);
        @(negedge clk);
        rst_n = 1'b0; sel_hi = hi; sel_lo = lo; ser_mode = sm; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 x in reset", 32'(ofs_x), 32'd0);
        chk("R1 y in reset", 32'(ofs_y), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst_n = 1'b1; sel_hi = 1'b1; sel_lo = 1'($urandom); ser_mode = 1'($urandom);
    endtask

    task automatic run_preset(input logic [1:0] c);
        do_reset(c[1], c[0], 1'($urandom));
        noise_bus();
        @(negedge clk);
        chk("R3 done after first edge", 32'(done), 32'd1);
        chk("R2 preset x", 32'(ofs_x), 32'(preset_exp(c)));
        chk("R2 preset y", 32'(ofs_y), 32'(preset_exp(c)));
        for (int i = 0; i < 4; i++) begin
            sel_hi = 1'($urandom); sel_lo = 1'($urandom); ser_mode = 1'($urandom);
            noise_bus();
            @(negedge clk);
        end
        chk("R10 preset x held", 32'(ofs_x), 32'(preset_exp(c)));
        chk("R5 preset y unaffected by writes", 32'(ofs_y), 32'(preset_exp(c)));
    endtask

    task automatic run_par(input int gap);
        logic [35:0] d1, d2;
        d1 = {4'($urandom), 32'($urandom)};
        d2 = {4'($urandom), 32'($urandom)};
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < gap; i++) begin
            wr_en = 1'b0; wr_data = {4'($urandom), 32'($urandom)};
            @(negedge clk);
        end
        chk("R4 no load while idle", 32'({done, ofs_x}), 32'd0);
        wr_en = 1'b1; wr_data = d1;
        @(negedge clk);
        chk("R4 first write loads x", 32'(ofs_x), 32'(d1[8:0]));
        chk("R4 done low after one write", 32'(done), 32'd0);
        for (int i = 0; i < gap; i++) begin
            wr_en = 1'b0; wr_data = {4'($urandom), 32'($urandom)};
            sel_hi = 1'($urandom); sel_lo = 1'($urandom);
            @(negedge clk);
        end
        wr_en = 1'b1; wr_data = d2;
        @(negedge clk);
        chk("R4 second write loads y", 32'(ofs_y), 32'(d2[8:0]));
        chk("R4 x kept", 32'(ofs_x), 32'(d1[8:0]));
        chk("R4 done after second write", 32'(done), 32'd1);
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; wr_data = {4'($urandom), 32'($urandom)};
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R5 extra writes ignored", 32'({ofs_y, ofs_x}), 32'({d2[8:0], d1[8:0]}));
    endtask

    task automatic run_ser(input logic [SER_BITS-1:0] pat, input bit gaps);
        logic [SER_BITS-1:0] sr;
        sr = '0;
        do_reset(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < SER_BITS; i++) begin
            if (gaps && ($urandom % 2 == 0)) begin
                sel_hi = 1'b1; sel_lo = 1'($urandom); noise_bus();
                @(negedge clk);
                chk("R6 enable high holds chain", 32'({ofs_y, ofs_x}), 32'(sr));
            end
            sel_hi = 1'b0; sel_lo = pat[SER_BITS-1-i]; noise_bus();
            @(negedge clk);
            sr = {sr[SER_BITS-2:0], pat[SER_BITS-1-i]};
            chk("R6 shift step", 32'({ofs_y, ofs_x}), 32'(sr));
            chk("R8 done timing", 32'(done), 32'(i == SER_BITS - 1));
        end
        chk("R7 first bit in y msb", 32'(ofs_y[OFS_W-1]), 32'(pat[SER_BITS-1]));
        chk("R7 last bit in x lsb", 32'(ofs_x[0]), 32'(pat[0]));
        for (int i = 0; i < 3; i++) begin
            sel_hi = 1'b0; sel_lo = ~sel_lo; noise_bus();
            @(negedge clk);
        end
        sel_hi = 1'b1; wr_en = 1'b0;
        chk("R9 extra bits ignored", 32'({ofs_y, ofs_x}), 32'(pat));
        chk("R10 done stays high", 32'(done), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2/R3 directed presets
        run_preset(2'b01);
        run_preset(2'b10);
        run_preset(2'b11);
        // R1: the last reset edge decides
        @(negedge clk);
        rst_n = 1'b0; sel_hi = 1'b1; sel_lo = 1'b1; ser_mode = 1'b0;
        @(negedge clk);
        sel_hi = 1'b0; sel_lo = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; sel_hi = 1'b1; sel_lo = 1'b0;
        @(negedge clk);
        chk("R1 last reset sample wins", 32'(ofs_x), 32'd8);
        // R4/R5 parallel
        run_par(0);
        run_par(3);
        // R7 bit order corner patterns
        run_ser(18'h20000, 1'b0);
        run_ser(18'h00001, 1'b1);
        run_ser(18'h3FFFF, 1'b1);
        // random mix
        for (int k = 0; k < 12; k++) begin
            case ($urandom % 3)
                0: run_preset(2'(1 + ($urandom % 3)));
                1: run_par(int'($urandom % 4));
                default: run_ser(18'($urandom), 1'b1);
            endcase
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule